// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked system to an external asynchronous static RAM of 32K words by 8 bits. On the user side, a request is accepted in any cycle where both request and ready are high. The request carries a read/write flag, an address and write data. Read results come back on a data bus and are marked by a one-cycle valid strobe.

On the memory side, the controller drives the address and three active-low strobes: select, write and read-enable. The shared data bus is handled through a pad-style triple of ports: outgoing data, a drive enable and incoming data. Every strobe comes straight from a flop, so none of them can glitch.

All timing comes from picosecond parameters and the clock period. Each value is rounded up to whole cycles. These counts set the read access window, the write pulse, the bus release gap after the memory stops driving, and the start-up wait after reset. A write is the overlap of the select and write strobes. Both strobes rise together to end it, and the address and data stay on the bus for one more cycle after that edge.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset is released, ready stays low and all three strobes stay high for exactly the start-up count of cycles (12500 at an 8 ns clock with default timings). Ready first rises in the cycle after that count ends, and no request is accepted before then.
- R2: A read holds select and read-enable low with write high for exactly the read count of cycles (2 at 8 ns). The address does not change during that time.
- R3: Read data is sampled from the bus on the clock edge that ends the read strobe. It is presented with a valid strobe one cycle wide, and it equals the last byte written to that address (0x00 for an address never written).
- R4: A write holds select and write low together, with read-enable high, for exactly the write count of cycles (1 at 8 ns). The controller drives the data for the whole pulse. Address and data stay unchanged through the pulse and through the cycle after both strobes rise.
- R5: The controller never drives the data bus while read-enable is low. It also keeps the bus released for the release count of cycles after read-enable rises.
- R6: The data drive is off in the cycle before read-enable falls.
- R7: While ready is high, all three strobes are high and the data drive is off. Reset puts the block in this state, but with ready low.
- R8: A request raised while ready is low starts no access and changes no memory content.
- R9: A write never produces a read-valid strobe, so the number of valid strobes equals the number of reads accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_req | input | 1 | Access request |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_addr | input | 15 | Word address |
| usr_wdata | input | 8 | Write data |
| usr_ready | output | 1 | Controller can accept a request |
| usr_rdata | output | 8 | Read data |
| usr_rvalid | output | 1 | One-cycle strobe marking usr_rdata |
| mem_addr | output | 15 | Memory address |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_rden_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_drive | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 8 | Data from the resolved bus |

## Verification
There are two places where two functions meet on the same clock edge.

The first is the end of a read and the controller's own bus drive. The memory keeps driving for a short time after read-enable rises, and a write can be requested on the very next edge that ready allows. The bench issues a write straight after each read. Its memory model keeps driving for 5 ns after the strobe rises, and any overlap with the controller's drive enable is judged a contention failure.

The second is a request that arrives while an access is still running. The bench raises a write request in the cycle right after a read is accepted. It then checks that the number of select falling edges still equals the number of accepted requests, and that a later read of that address returns the old byte.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RD_REC,
      ST_WR,
      ST_WR_END
   } ctrl_state_e;

   // whole cycles needed to cover a delay, rounded up
   function automatic int cyc_ceil(input int delay_ps, input int period_ps);
      return (delay_ps + period_ps - 1) / period_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_pwrup_wait.sv
`timescale 1ns/1ps
module sram_pwrup_wait #(
   parameter int WAIT_CYC = 10000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);

   generate
      if (WAIT_CYC == 0) begin : g_no_wait
         assign done = 1'b1;
      end else begin : g_wait
         localparam int CW = $clog2(WAIT_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);
         logic [CW-1:0] cnt;
         logic          done_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               cnt    <= cnt + 1'b1;
               done_q <= (cnt == LAST);
            end
         end

         assign done = done_q;

         // once the wait has elapsed it never re-arms
         assert_wait_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
            done_q |=> done_q);
      end
   endgenerate

endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign count = cnt_q;
   assign last  = (cnt_q == '0);

   // phase length depends on a strict one-per-cycle count down
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= cap;
         if (cap) dout <= din;
      end
   end

   // captured byte is the bus value at the sampling edge
   assert_capture_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (dout == $past(din)));

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W          = 15,
   parameter int DATA_W          = 8,
   parameter int CLK_PERIOD_PS   = 10000,
   parameter int T_ACCESS_PS     = 10000,
   parameter int T_RD_CYCLE_PS   = 10000,
   parameter int T_WR_PULSE_PS   = 7000,
   parameter int T_WR_WINDOW_PS  = 7000,
   parameter int T_DATA_SETUP_PS = 5000,
   parameter int T_WR_CYCLE_PS   = 10000,
   parameter int T_RELEASE_PS    = 5000,
   parameter int T_WR_RELEASE_PS = 6000,
   parameter int T_STARTUP_PS    = 100_000_000,
   parameter bit OE_LOW_WRITE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usr_req,
   input  logic              usr_write,
   input  logic [ADDR_W-1:0] usr_addr,
   input  logic [DATA_W-1:0] usr_wdata,
   output logic              usr_ready,
   output logic [DATA_W-1:0] usr_rdata,
   output logic              usr_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_wr_n,
   output logic              mem_rden_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_drive,
   input  logic [DATA_W-1:0] mem_dq_in
);

   // ---------------- derived cycle counts ----------------
   localparam int RD_CYC  = imax(imax(cyc_ceil(T_ACCESS_PS, CLK_PERIOD_PS),
                                      cyc_ceil(T_RD_CYCLE_PS, CLK_PERIOD_PS)), 1);
   localparam int DRV_DLY = OE_LOW_WRITE ? cyc_ceil(T_WR_RELEASE_PS, CLK_PERIOD_PS) : 0;
   localparam int SD_CYC  = imax(cyc_ceil(T_DATA_SETUP_PS, CLK_PERIOD_PS), 1);
   localparam int WR_CYC  = imax(imax(cyc_ceil(T_WR_PULSE_PS, CLK_PERIOD_PS),
                                      cyc_ceil(T_WR_WINDOW_PS, CLK_PERIOD_PS)),
                                 imax(DRV_DLY + SD_CYC,
                                      cyc_ceil(T_WR_CYCLE_PS, CLK_PERIOD_PS) - 1));
   localparam int TA_CYC  = imax(cyc_ceil(T_RELEASE_PS, CLK_PERIOD_PS), 1);
   localparam int PWR_CYC = cyc_ceil(T_STARTUP_PS, CLK_PERIOD_PS);
   localparam int TMR_W   = $clog2(imax(imax(RD_CYC, WR_CYC), TA_CYC) + 1);

   localparam logic [TMR_W-1:0] RD_LOAD    = TMR_W'(RD_CYC - 1);
   localparam logic [TMR_W-1:0] WR_LOAD    = TMR_W'(WR_CYC - 1);
   localparam logic [TMR_W-1:0] TA_LOAD    = TMR_W'(TA_CYC - 1);
   localparam logic [TMR_W-1:0] DRV_SET_AT = TMR_W'(WR_CYC - DRV_DLY);

   // ---------------- elaboration checks ----------------
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: address and data widths must be positive");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_clk
         $error("sram_async_ctrl: clock period must be positive");
      end
      if (T_ACCESS_PS < 0 || T_WR_PULSE_PS < 0 || T_STARTUP_PS < 0) begin : g_bad_time
         $error("sram_async_ctrl: timing parameters must not be negative");
      end
   endgenerate

   // ---------------- sub-blocks ----------------
   ctrl_state_e      state;
   logic             pwr_done;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic [TMR_W-1:0] tmr_cnt;
   logic             tmr_last;
   logic             accept;
   logic             cap_en;

   sram_pwrup_wait #(.WAIT_CYC(PWR_CYC)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_done)
   );

   sram_phase_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .count    (tmr_cnt),
      .last     (tmr_last)
   );

   sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap_en),
      .din   (mem_dq_in),
      .dout  (usr_rdata),
      .valid (usr_rvalid)
   );

   // ---------------- control ----------------
   assign usr_ready = pwr_done && (state == ST_IDLE);
   assign accept    = usr_req && usr_ready;
   assign cap_en    = (state == ST_RD) && tmr_last;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = TA_LOAD;
      if (accept) begin
         tmr_load = 1'b1;
         tmr_val  = usr_write ? WR_LOAD : RD_LOAD;
      end else if (cap_en) begin
         tmr_load = 1'b1;
         tmr_val  = TA_LOAD;
      end
   end

   logic              sel_q, wr_q, rden_q, drv_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         sel_q  <= 1'b1;
         wr_q   <= 1'b1;
         rden_q <= 1'b1;
         drv_q  <= 1'b0;
         addr_q <= '0;
         wdat_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= usr_addr;
                  wdat_q <= usr_wdata;
                  sel_q  <= 1'b0;
                  if (usr_write) begin
                     state  <= ST_WR;
                     wr_q   <= 1'b0;
                     rden_q <= !OE_LOW_WRITE;
                     drv_q  <= (DRV_DLY == 0);
                  end else begin
                     state  <= ST_RD;
                     rden_q <= 1'b0;
                  end
               end
            end
            ST_RD: begin
               if (tmr_last) begin
                  state  <= ST_RD_REC;
                  sel_q  <= 1'b1;
                  rden_q <= 1'b1;
               end
            end
            ST_RD_REC: begin
               if (tmr_last) state <= ST_IDLE;
            end
            ST_WR: begin
               if (tmr_cnt == DRV_SET_AT) drv_q <= 1'b1;
               if (tmr_last) begin
                  state  <= ST_WR_END;
                  sel_q  <= 1'b1;
                  wr_q   <= 1'b1;
                  rden_q <= 1'b1;
               end
            end
            ST_WR_END: begin
               state <= ST_IDLE;
               drv_q <= 1'b0;
            end
            default: begin
               state  <= ST_IDLE;
               sel_q  <= 1'b1;
               wr_q   <= 1'b1;
               rden_q <= 1'b1;
               drv_q  <= 1'b0;
            end
         endcase
      end
   end

   assign mem_addr     = addr_q;
   assign mem_dq_out   = wdat_q;
   assign mem_sel_n    = sel_q;
   assign mem_wr_n     = wr_q;
   assign mem_rden_n   = rden_q;
   assign mem_dq_drive = drv_q;

   // ---------------- assertions ----------------
   assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_done |-> (mem_sel_n && mem_wr_n && mem_rden_n && !mem_dq_drive));

   assert_rd_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rden_n && mem_wr_n && $past(!mem_rden_n)) |-> $stable(mem_addr));

   assert_rvalid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      usr_rvalid |=> !usr_rvalid);

   assert_write_in_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> !mem_sel_n);

   assert_wr_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_wr_n)) |-> (mem_dq_drive && $stable(mem_dq_out) && $stable(mem_addr)));

   generate
      if (!OE_LOW_WRITE) begin : g_chk_nocontend
         assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_dq_drive && !mem_rden_n));
      end
   endgenerate

   assert_drive_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(mem_rden_n) && mem_wr_n) |-> !$past(mem_dq_drive));

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      usr_ready |-> (mem_sel_n && mem_wr_n && mem_rden_n && !mem_dq_drive));

   assert_busy_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_req && !usr_ready && mem_sel_n) |=> mem_sel_n);

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

   localparam int AW      = 15;
   localparam int DW      = 8;
   localparam int RD_EXP  = 2;      // 10 ns access at 8 ns clock
   localparam int WR_EXP  = 1;      // 7 ns pulse, 10 ns cycle incl. end cycle
   localparam int PWR_EXP = 12500;  // 100 us at 8 ns

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          usr_req = 1'b0, usr_write = 1'b0;
   logic [AW-1:0] usr_addr = '0;
   logic [DW-1:0] usr_wdata = '0;
   logic          usr_ready, usr_rvalid;
   logic [DW-1:0] usr_rdata;
   logic [AW-1:0] mem_addr;
   logic          mem_sel_n, mem_wr_n, mem_rden_n, mem_dq_drive;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   sram_async_ctrl #(.CLK_PERIOD_PS(8000)) dut (
      .clk(clk), .rst_n(rst_n),
      .usr_req(usr_req), .usr_write(usr_write), .usr_addr(usr_addr), .usr_wdata(usr_wdata),
      .usr_ready(usr_ready), .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid),
      .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n), .mem_rden_n(mem_rden_n),
      .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
   );

   // ---------------- memory model ----------------
   logic [DW-1:0] mem    [int];
   logic [DW-1:0] shadow [int];
   logic          mdrv = 1'b0;
   logic [DW-1:0] mdat = 8'hxx;
   wire rd_sel = !mem_sel_n && mem_wr_n && !mem_rden_n;
   wire wr_act = !mem_sel_n && !mem_wr_n;

   always_comb mem_dq_in = mdrv ? mdat : (mem_dq_drive ? mem_dq_out : 8'hzz);

   always @(negedge wr_act) if (rst_n) mem[int'(mem_addr)] = mem_dq_in;

   initial forever begin
      wait (rd_sel === 1'b1);
      mdrv = 1'b1; mdat = 8'hxx;
      #10;
      if (rd_sel === 1'b1)
         mdat = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
      wait (rd_sel !== 1'b1);
      #5;
      mdrv = 1'b0; mdat = 8'hxx;
   end

   // ---------------- bookkeeping ----------------
   int n_chk = 0, n_err = 0;
   int acc_issued = 0, acc_seen = 0, rd_issued = 0, rv_seen = 0;
   logic [DW-1:0] exp_q [$];
   logic [AW-1:0] expa_q [$];
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   function automatic logic [DW-1:0] exp_val(input logic [AW-1:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
   endfunction

   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      while (!usr_ready) @(negedge clk);
      usr_req = 1'b1; usr_write = w; usr_addr = a; usr_wdata = d;
      if (w) shadow[int'(a)] = d;
      else begin
         exp_q.push_back(exp_val(a));
         expa_q.push_back(a);
         rd_issued++;
      end
      acc_issued++;
      @(negedge clk);
      usr_req = 1'b0;
   endtask

   // ---------------- monitor / scoreboard ----------------
   int wr_run = 0, rd_run = 0;
   logic prev_drive = 1'b0, prev_sel = 1'b1, prev_rv = 1'b0;
   logic [AW-1:0] snap_a;
   logic [DW-1:0] snap_d;

   always @(negedge clk) if (rst_n && !done_flag) begin
      if (mem_dq_drive && mdrv)
         chk(1'b0, "R5", "bus contention", 1, 0);
      if (usr_ready)
         chk(mem_sel_n && mem_wr_n && mem_rden_n && !mem_dq_drive, "R7", "idle strobes",
             {mem_sel_n, mem_wr_n, mem_rden_n, mem_dq_drive}, 4'b1110);
      if (!mem_sel_n && prev_sel) acc_seen++;
      // write pulse shape
      if (!mem_wr_n) begin
         if (wr_run == 0) begin snap_a = mem_addr; snap_d = mem_dq_out; end
         chk(!mem_sel_n && mem_rden_n && mem_dq_drive, "R4", "write strobes",
             {mem_sel_n, mem_rden_n, mem_dq_drive}, 3'b011);
         chk(mem_addr == snap_a && mem_dq_out == snap_d, "R4", "write addr/data stable",
             int'(mem_dq_out), int'(snap_d));
         wr_run++;
      end else if (wr_run > 0) begin
         chk(wr_run == WR_EXP, "R4", "write pulse cycles", wr_run, WR_EXP);
         chk(mem_dq_drive && mem_addr == snap_a && mem_dq_out == snap_d, "R4",
             "hold after write end", int'(mem_dq_out), int'(snap_d));
         wr_run = 0;
      end
      // read strobe shape
      if (!mem_rden_n && mem_wr_n) begin
         if (rd_run == 0) begin
            chk(!prev_drive, "R6", "drive off before read", prev_drive, 0);
            snap_a = mem_addr;
         end
         chk(!mem_sel_n && mem_addr == snap_a, "R2", "read select/addr",
             int'(mem_addr), int'(snap_a));
         rd_run++;
      end else if (rd_run > 0) begin
         chk(rd_run == RD_EXP, "R2", "read strobe cycles", rd_run, RD_EXP);
         rd_run = 0;
      end
      // read results
      if (usr_rvalid) begin
         rv_seen++;
         chk(!prev_rv, "R3", "valid width", 2, 1);
         if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected valid", 1, 0);
         else begin
            logic [DW-1:0] e;
            logic [AW-1:0] ea;
            e = exp_q.pop_front();
            ea = expa_q.pop_front();
            chk(usr_rdata === e, "R3", $sformatf("read data @0x%0h", ea), int'(usr_rdata), int'(e));
         end
      end
      prev_drive = mem_dq_drive;
      prev_sel   = mem_sel_n;
      prev_rv    = usr_rvalid;
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, actual %0d expected %0d", 1, 0);
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      chk(!usr_ready && !usr_rvalid, "R7", "reset ready/valid", {usr_ready, usr_rvalid}, 0);
      chk(mem_sel_n && mem_wr_n && mem_rden_n && !mem_dq_drive, "R7", "reset strobes",
          {mem_sel_n, mem_wr_n, mem_rden_n, mem_dq_drive}, 4'b1110);
      rst_n = 1'b1;

      // start-up wait with stray requests (R1, R8)
      cyc = 0;
      while (!usr_ready && cyc < PWR_EXP + 10) begin
         @(negedge clk);
         cyc++;
         usr_req = (cyc % 1000 == 5); usr_write = cyc[1]; usr_addr = AW'(cyc);
         if (!usr_ready)
            chk(mem_sel_n && mem_wr_n && mem_rden_n, "R1", "strobes during wait",
                {mem_sel_n, mem_wr_n, mem_rden_n}, 3'b111);
      end
      usr_req = 1'b0;
      chk(cyc >= PWR_EXP && cyc <= PWR_EXP + 1, "R1", "start-up cycles", cyc, PWR_EXP);
      chk(acc_seen == 0, "R8", "access during wait", acc_seen, 0);

      // boundary addresses and data
      issue(1'b1, 15'h0000, 8'h00);
      issue(1'b1, 15'h7FFF, 8'hFF);
      issue(1'b1, 15'h1234, 8'hA5);
      issue(1'b0, 15'h0000, 8'h00);
      issue(1'b0, 15'h7FFF, 8'h00);
      issue(1'b0, 15'h1234, 8'h00);
      issue(1'b0, 15'h4000, 8'h00);   // never written

      // walking pattern: writes then reads
      for (int i = 0; i < 16; i++) issue(1'b1, AW'(i * 16'h0811), DW'(i * 17 + 3));
      for (int i = 15; i >= 0; i--) issue(1'b0, AW'(i * 16'h0811), 8'h00);

      // alternating read/write at one address: turnaround in both directions (R5, R6)
      for (int i = 0; i < 8; i++) begin
         issue(1'b0, 15'h2222, 8'h00);
         issue(1'b1, 15'h2222, DW'(8'h3C ^ i));
      end
      issue(1'b0, 15'h2222, 8'h00);

      // request while busy must be ignored (R8)
      issue(1'b0, 15'h0ABC, 8'h00);
      usr_req = 1'b1; usr_write = 1'b1; usr_addr = 15'h0ABC; usr_wdata = 8'h5A;
      @(negedge clk);
      usr_req = 1'b0;
      issue(1'b0, 15'h0ABC, 8'h00);

      // writes only: no valid strobes expected (R9)
      for (int i = 0; i < 4; i++) issue(1'b1, AW'(16'h6000 + i), DW'(8'hC0 + i));
      for (int i = 0; i < 4; i++) issue(1'b0, AW'(16'h6000 + i), 8'h00);

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "pending reads", exp_q.size(), 0);
      chk(rv_seen == rd_issued, "R9", "valid count", rv_seen, rd_issued);
      chk(acc_seen == acc_issued, "R8", "access count", acc_seen, acc_issued);
      finish_run();
   end

endmodule